// File: doc/BRIEF.md
# ADC Command Decoder and Channel Register File

This block is the digital control front of a serial multichannel converter. A host writes 8-bit command words over a serial link, with data sampled on SCLK rising edges while the active-low select is low. The block oversamples the serial pins with a system clock. It frames each word from a free-floating start bit. It then sorts the word into one of three kinds: a conversion request, a per-channel setup write or a mode write.

The block keeps one setup register per channel, holding a differential flag and a 3-bit range code. It also keeps a conversion-mode register and a power state. For each accepted conversion request it drives a one-cycle request pulse, the selected channel and that channel's effective setup. In a differential pair, the setup comes from the even (positive) channel. The block also tells the converter which power-down level applies. The result readout path is outside this block. It only reports whether a result is still pending and which result bit goes out next, which the block uses to decide when a new start bit may be framed.

Top module: `adc_cmd_ctrl`

## Requirements
- R1: While select is low, zeros before the first 1 on `din` are skipped. That first 1 is bit 7 of a command word, and the next seven sampled bits complete it, MSB first.
- R2: While select is high, `sclk` and `din` have no effect. Raising select in the middle of a word discards the partial word.
- R3: Word kind comes from bits 3:0. The value 0000 is a conversion request with channel in bits 6:4. The value 1000 is a mode write with mode code in bits 6:4. Any other value is a setup write with channel in bits 6:4, differential flag in bit 3 and range code in bits 2:0.
- R4: Each channel has its own setup register. An accepted conversion request drives `conv_chan` with that channel and drives `conv_diff`/`conv_range` from its register. After reset every register is single-ended with range `RANGE_DEFAULT`.
- R5: A request for an odd channel whose even partner is set differential is reserved. It makes no pulse and sets `cmd_err`.
- R6: Setup writes to channels at or above `NCH` are dropped. Requests for those channels report single-ended with `RANGE_DEFAULT`.
- R7: Mode codes 000, 001 and 010 select external clock, external acquisition and internal clock, shown as 0, 1 and 2 on `conv_mode`. They also return the power state to full power. Codes 011 and 101 change nothing.
- R8: Mode code 100 restores every setup register, the conversion mode (0), full power and a clear `cmd_err`.
- R9: Code 110 enters partial power-down from full power or from partial power-down, and is ignored in full power-down. Code 111 enters full power-down. Power-down is left only by codes 000, 001, 010, 100 or 111. Select toggling alone never leaves it.
- R10: A conversion request made during either power-down produces no pulse and sets the sticky `cmd_err`.
- R11: With `rd_pending` high, a start bit is framed only when `rd_next_bit` is below 3 in mode 0, below 7 in mode 1, or below 4 in mode 2. With `rd_pending` low, a start bit is always framed.
- R12: `conv_req` is high for exactly one clock per accepted request. `conv_chan`, `conv_diff` and `conv_range` hold their values until the next accepted request.
- R13: `pd_partial` and `pd_full` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| din | input | 1 | Serial command data |
| rd_pending | input | 1 | A previous result is not yet fully shifted out |
| rd_next_bit | input | 4 | Index of the next result bit to be shifted |
| conv_mode | output | 2 | Active conversion mode (0, 1, 2) |
| conv_req | output | 1 | One-cycle pulse per accepted conversion request |
| conv_chan | output | 3 | Channel of the last accepted request |
| conv_diff | output | 1 | Differential flag for that request |
| conv_range | output | 3 | Range code for that request |
| pd_partial | output | 1 | Partial power-down active |
| pd_full | output | 1 | Full power-down active |
| cmd_err | output | 1 | Sticky flag for refused requests |

## Verification
The assertions assume that `cs_n`, `sclk` and `din` each stay steady for several system clocks around every SCLK edge, so that the two-stage input sampler sees each serial bit exactly once. They also assume `rd_pending` and `rd_next_bit` do not change in the middle of a word. The bench moves the serial pins only every four system clocks and changes the readout inputs only while select is high. It also leaves select high for several clocks between words, so each word is framed cleanly before the next one starts.

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl #(
  parameter int          NCH           = 8,
  parameter logic [2:0]  RANGE_DEFAULT = 3'b001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       din,
  input  logic       rd_pending,
  input  logic [3:0] rd_next_bit,
  output logic [1:0] conv_mode,
  output logic       conv_req,
  output logic [2:0] conv_chan,
  output logic       conv_diff,
  output logic [2:0] conv_range,
  output logic       pd_partial,
  output logic       pd_full,
  output logic       cmd_err
);
  localparam int MAXCH = 8;
  localparam logic [1:0] PD_NONE = 2'd0, PD_PART = 2'd1, PD_FULL = 2'd2;

  logic [2:0] sy1, sy2;
  logic       sclk_d;
  logic       in_word;
  logic [2:0] cnt;
  logic [6:0] sh;
  logic [1:0] pd;
  logic       cfg_diff [MAXCH];
  logic [2:0] cfg_rng  [MAXCH];
  logic [3:0] thr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1    <= 3'b100;
      sy2    <= 3'b100;
      sclk_d <= 1'b0;
    end else begin
      sy1    <= {cs_n, sclk, din};
      sy2    <= sy1;
      sclk_d <= sy2[1];
    end

  wire       sel   = !sy2[2];
  wire       rise  = sel && sy2[1] && !sclk_d;
  wire       bit_i = sy2[0];

  always_comb
    case (conv_mode)
      2'd0:    thr = 4'd3;
      2'd1:    thr = 4'd7;
      default: thr = 4'd4;
    endcase

  wire       start_ok = !rd_pending || (rd_next_bit < thr);
  wire       done     = rise && in_word && (cnt == 3'd7);
  wire [7:0] word     = {sh, bit_i};
  wire [2:0] ch       = word[6:4];
  wire       is_conv  = word[3:0] == 4'b0000;
  wire       is_mode  = word[3:0] == 4'b1000;
  wire       reserved = ch[0] && cfg_diff[{ch[2:1], 1'b0}];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_word <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
    end else if (!sel) begin
      in_word <= 1'b0;
    end else if (rise) begin
      if (!in_word) begin
        if (bit_i && start_ok) begin
          in_word <= 1'b1;
          cnt     <= 3'd1;
          sh      <= 7'd1;
        end
      end else begin
        sh  <= {sh[5:0], bit_i};
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) in_word <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      conv_mode  <= 2'd0;
      conv_req   <= 1'b0;
      conv_chan  <= '0;
      conv_diff  <= 1'b0;
      conv_range <= RANGE_DEFAULT;
      pd         <= PD_NONE;
      cmd_err    <= 1'b0;
      for (int i = 0; i < MAXCH; i++) begin
        cfg_diff[i] <= 1'b0;
        cfg_rng[i]  <= RANGE_DEFAULT;
      end
    end else begin
      conv_req <= 1'b0;
      if (done) begin
        if (is_conv) begin
          if (pd != PD_NONE || reserved) cmd_err <= 1'b1;
          else begin
            conv_req   <= 1'b1;
            conv_chan  <= ch;
            conv_diff  <= cfg_diff[ch];
            conv_range <= cfg_rng[ch];
          end
        end else if (is_mode) begin
          case (ch)
            3'b000, 3'b001, 3'b010: begin
              conv_mode <= ch[1:0];
              pd        <= PD_NONE;
            end
            3'b100: begin
              conv_mode <= 2'd0;
              pd        <= PD_NONE;
              cmd_err   <= 1'b0;
              for (int i = 0; i < MAXCH; i++) begin
                cfg_diff[i] <= 1'b0;
                cfg_rng[i]  <= RANGE_DEFAULT;
              end
            end
            3'b110: if (pd != PD_FULL) pd <= PD_PART;
            3'b111: pd <= PD_FULL;
            default: ;
          endcase
        end else if (int'(ch) < NCH) begin
          cfg_diff[ch] <= word[3];
          cfg_rng[ch]  <= word[2:0];
        end
      end
    end

  assign pd_partial = pd == PD_PART;
  assign pd_full    = pd == PD_FULL;
endmodule

module adc_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [1:0] conv_mode,
  input logic       conv_req,
  input logic       pd_partial,
  input logic       pd_full,
  input logic       cmd_err
);
  assert_pd_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_partial, pd_full}));
  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  assert_req_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (!pd_partial && !pd_full));
  assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |->
      (!conv_req && $stable(pd_full) && $stable(pd_partial)));
  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_mode != 2'b11);
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_err) |-> (conv_mode == 2'd0 && !pd_partial && !pd_full));
  assert_full_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_full) |-> !pd_partial);
endmodule

bind adc_cmd_ctrl adc_cmd_ctrl_chk u_chk (.*);

// File: tb/adc_cmd_ctrl_bench.sv
module adc_cmd_ctrl_bench;
  localparam int         NCH  = 6;
  localparam logic [2:0] RDEF = 3'b001;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, din = 0, rd_pending = 0;
  logic [3:0] rd_next_bit = 0;
  logic [1:0] conv_mode;
  logic conv_req, conv_diff, pd_partial, pd_full, cmd_err;
  logic [2:0] conv_chan, conv_range;

  adc_cmd_ctrl #(.NCH(NCH), .RANGE_DEFAULT(RDEF)) u_adc_cmd_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, reqs = 0;
  bit finished = 0;
  always @(posedge clk) if (rst_n && conv_req) reqs++;

  bit mdiff [8];
  logic [2:0] mrng [8];
  int mmode, mpd;
  bit merr, ediff;
  logic [2:0] echan, erng;

  task automatic model_defaults();
    for (int i = 0; i < 8; i++) begin mdiff[i] = 0; mrng[i] = RDEF; end
    mmode = 0; mpd = 0; merr = 0;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_bit(bit b);
    din = b;
    repeat (4) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    sclk = 0;
  endtask

  task automatic send(logic [7:0] b, int lz);
    @(negedge clk);
    cs_n = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < lz; i++) drive_bit(0);
    for (int i = 7; i >= 0; i--) drive_bit(b[i]);
    repeat (6) @(negedge clk);
    cs_n = 1; din = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_cmd(logic [7:0] b, string tag, int lz = 0);
    int thr, ch, r0, ereq;
    thr = (mmode == 0) ? 3 : (mmode == 1) ? 7 : 4;
    ch = int'(b[6:4]);
    ereq = 0;
    if (!rd_pending || int'(rd_next_bit) < thr) begin
      if (b[3:0] == 4'b0000) begin
        if (mpd != 0 || (ch % 2 == 1 && mdiff[ch-1])) merr = 1;
        else begin ereq = 1; echan = b[6:4]; ediff = mdiff[ch]; erng = mrng[ch]; end
      end else if (b[3:0] == 4'b1000) begin
        case (ch)
          0, 1, 2: begin mmode = ch; mpd = 0; end
          4: model_defaults();
          6: if (mpd != 2) mpd = 1;
          7: mpd = 2;
          default: ;
        endcase
      end else if (ch < NCH) begin
        mdiff[ch] = b[3]; mrng[ch] = b[2:0];
      end
    end
    r0 = reqs;
    send(b, lz);
    chk({tag, " req"}, reqs - r0, ereq);
    chk({tag, " chan R12"}, int'(conv_chan), int'(echan));
    chk({tag, " diff R12"}, int'(conv_diff), int'(ediff));
    chk({tag, " range R12"}, int'(conv_range), int'(erng));
    chk({tag, " mode"}, int'(conv_mode), mmode);
    chk({tag, " partial R13"}, int'(pd_partial), int'(mpd == 1));
    chk({tag, " full R13"}, int'(pd_full), int'(mpd == 2));
    chk({tag, " err"}, int'(cmd_err), int'(merr));
  endtask

  task automatic idle_toggle(string tag);
    int r0 = reqs;
    cs_n = 1; din = 1;
    for (int i = 0; i < 20; i++) begin
      repeat (4) @(negedge clk); sclk = 1;
      repeat (4) @(negedge clk); sclk = 0;
    end
    din = 0;
    repeat (6) @(negedge clk);
    chk({tag, " idle req"}, reqs - r0, 0);
    chk({tag, " idle mode"}, int'(conv_mode), mmode);
    chk({tag, " idle partial"}, int'(pd_partial), int'(mpd == 1));
    chk({tag, " idle full"}, int'(pd_full), int'(mpd == 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_defaults();
    echan = 0; ediff = 0; erng = RDEF;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R4 reset mode", int'(conv_mode), 0);
    chk("R4 reset range", int'(conv_range), int'(RDEF));
    chk("R9 reset pd", int'(pd_partial | pd_full), 0);
    chk("R10 reset err", int'(cmd_err), 0);
    chk("R12 reset req", int'(conv_req), 0);

    for (int ch = 0; ch < 8; ch++) do_cmd({1'b1, 3'(ch), 4'b0000}, "R4 default");

    for (int ch = 0; ch < 8; ch++)
      for (int d = 0; d < 2; d++)
        for (int r = 1; r < 8; r++) begin
          do_cmd({1'b1, 3'(ch), 1'(d), 3'(r)}, "R3 R6 setup");
          do_cmd({1'b1, 3'(ch), 4'b0000}, "R4 R5 R6 convert");
        end

    do_cmd(8'b1100_1000, "R8 reset byte");
    do_cmd(8'b1011_0000, "R8 default after reset");

    do_cmd(8'b1001_0101, "R1 leading zeros", 3);
    do_cmd(8'b1001_0000, "R1 leading zeros", 5);

    idle_toggle("R2");
    @(negedge clk); cs_n = 0;
    repeat (3) @(negedge clk);
    drive_bit(1); drive_bit(0); drive_bit(1);
    cs_n = 1;
    repeat (6) @(negedge clk);
    do_cmd(8'b1011_1011, "R2 abort");
    do_cmd(8'b1010_0000, "R2 abort");

    do_cmd(8'b1001_1000, "R7 mode1");
    do_cmd(8'b1011_1000, "R7 code011");
    do_cmd(8'b1101_1000, "R7 code101");
    do_cmd(8'b1010_1000, "R7 mode2");
    do_cmd(8'b1000_1000, "R7 mode0");

    do_cmd(8'b1110_1000, "R9 partial");
    do_cmd(8'b1000_0000, "R10 conv in partial");
    idle_toggle("R9");
    do_cmd(8'b1011_1000, "R9 code011 stays");
    do_cmd(8'b1110_1000, "R9 partial again");
    do_cmd(8'b1111_1000, "R9 full");
    do_cmd(8'b1110_1000, "R9 partial in full");
    do_cmd(8'b1010_0000, "R10 conv in full");
    idle_toggle("R9");
    do_cmd(8'b1000_1000, "R9 exit mode0");
    do_cmd(8'b1110_1000, "R9 partial");
    do_cmd(8'b1001_1000, "R9 exit mode1");
    do_cmd(8'b1111_1000, "R9 full");
    do_cmd(8'b1010_1000, "R9 exit mode2");
    do_cmd(8'b1110_1000, "R9 partial");
    do_cmd(8'b1100_1000, "R9 exit reset");

    for (int m = 0; m < 3; m++) begin
      do_cmd({1'b1, 3'(m), 4'b1000}, "R11 mode");
      for (int k = 0; k < 16; k++) begin
        rd_pending = 1; rd_next_bit = 4'(k);
        do_cmd(8'b1000_0000, "R11 gate");
        rd_pending = 0;
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule